// File: doc/BRIEF.md
# USB Device Interrupt Status and Control Registers

This block holds two 16-bit registers of a USB device controller: an interrupt status word and a control word. Single-cycle event pulses from the rest of the controller set sticky flags in the status word. Software reads the word and acknowledges a flag by writing a zero into that bit position. A one written to a flag bit leaves that flag as it is.

The control word has one enable bit for each status flag, at the same bit position as the flag. The single interrupt line is high while any flag is set and its enable bit is also set. The low bits of the control word drive five power and bus-state controls: a forced bus reset, power down, a low-power mode, a forced suspend and a resume request.

The transfer-complete flag at the top of the status word is not stored in this block. It follows the per-endpoint completion inputs, and the low five bits of the status word report the lowest-numbered endpoint with a completion pending, together with that endpoint's direction. Software reaches both registers through a plain register port. Writes take effect at the clock edge, and the read data is combinational from the selected register.

Top module: `usbEvtRegs`

## Requirements
- R1: After reset the status word reads 0x0000 when no endpoint is pending, the control word reads 0x0003, irq is 0, forceReset and powerDown are 1, and the other three controls are 0.
- R2: A one-cycle pulse on an event input sets its status flag from the next clock edge on. The mapping from input to status bit is: evtIn[0] to bit 8 (expected frame start), evtIn[1] to bit 9 (frame start), evtIn[2] to bit 10 (bus reset), evtIn[3] to bit 11 (suspend), evtIn[4] to bit 12 (wakeup), evtIn[5] to bit 13 (error), evtIn[6] to bit 14 (DMA over/underrun), and shortPktEvt to bit 7 (short or zero-length packet received).
- R3: A status write (regAddr = 0) clears each flag in bits 14..7 whose data bit is 0. Flags whose data bit is 1 keep their value.
- R4: An event that arrives in the same cycle as a status write clearing its flag leaves the flag set.
- R5: Status bit 15 reads 1 exactly while any epDone input is 1. A status write does not change it.
- R6: Status bits 3..0 show the index of the lowest-numbered endpoint whose epDone is 1, and bit 4 shows that endpoint's epDir. All five bits read 0 when no endpoint is pending. Writes have no effect on them.
- R7: A control write (regAddr = 1) stores bits 15..7 as interrupt enables and bits 4..0 as controls. Control bits 6..5 and status bits 6..5 always read 0.
- R8: The control outputs follow the stored control bits: resumeReq is bit 4, forceSuspend is bit 3, lowPower is bit 2, powerDown is bit 1 and forceReset is bit 0.
- R9: irq is 1 exactly while some status bit in 15..7 is 1 and the control bit at the same position is 1.
- R10: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 control (read and write) |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| evtIn | input | 7 | Event pulses for status bits 14..8 |
| shortPktEvt | input | 1 | Short/zero-length packet event pulse for status bit 7 |
| epDone | input | NUM_EP | Per-endpoint transfer-complete levels |
| epDir | input | NUM_EP | Per-endpoint transfer direction |
| irq | output | 1 | Interrupt request |
| resumeReq | output | 1 | Resume request control |
| forceSuspend | output | 1 | Forced suspend control |
| lowPower | output | 1 | Low-power mode control |
| powerDown | output | 1 | Power down control |
| forceReset | output | 1 | Forced bus reset control |

## Verification
A flag that is stored wrongly, or is cleared by the wrong data bit, shows on the status read one cycle after the pulse or the write that caused it. If its enable bit is set, the same fault shows on irq at that time. A fault in the endpoint selection shows at once in the low five bits of the status read, because those bits are combinational from epDone and epDir. A mixed-up control bit shows on its control output one cycle after the control write. The bench drives each event alone and all events together, clears flags with patterns that contain both ones and zeros, makes an event collide with a clear, and moves the pending endpoint between index 0, a middle index and the top index.

// File: rtl/usbEvtPkg.sv
package usbEvtPkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_EVT   = 7;   // latched flags in bits 14..8
  localparam int unsigned EVT_LO    = 8;
  localparam int unsigned SHORT_BIT = 7;
  localparam int unsigned DIR_BIT   = 4;
  localparam int unsigned XFER_BIT  = 15;
  localparam int unsigned EP_ID_W   = 4;
  localparam int unsigned CTL_W     = 5;
  localparam int unsigned MASK_W    = XFER_BIT - SHORT_BIT + 1; // bits 15..7
  localparam logic [CTL_W-1:0] CTL_RESET = 5'b00011;

  typedef struct packed {
    logic              wrStatus;
    logic              wrCtrl;
    logic [WORD_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/usbEvtCtrl.sv
module usbEvtCtrl
  import usbEvtPkg::*;
(
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe.wrStatus = regWrEn && !regAddr;
    strobe.wrCtrl   = regWrEn && regAddr;
    strobe.data     = regWrData;
  end
endmodule

// File: rtl/usbEpSelect.sv
module usbEpSelect
  import usbEvtPkg::*;
#(
  parameter int unsigned NUM_EP = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EP-1:0]  epDone,
  input  logic [NUM_EP-1:0]  epDir,
  output logic               anyPending,
  output logic [EP_ID_W-1:0] epIdSel,
  output logic               epDirSel
);
  // Scan from the top down so that the lowest pending index wins.
  always_comb begin
    epIdSel  = '0;
    epDirSel = 1'b0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (epDone[i]) begin
        epIdSel  = EP_ID_W'(i);
        epDirSel = epDir[i];
      end
    end
  end

  assign anyPending = |epDone;

  // R6: the reported endpoint really has a completion pending
  p_id_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |-> epDone[epIdSel]);

  // R6: no pending endpoint means the id and direction fields read zero
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !anyPending |-> (epIdSel == '0 && !epDirSel));
endmodule

// File: rtl/usbEvtDatapath.sv
module usbEvtDatapath
  import usbEvtPkg::*;
#(
  parameter bit HAS_SHORT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic               regAddr,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               shortPktEvt,
  input  logic               anyPending,
  input  logic [EP_ID_W-1:0] epIdSel,
  input  logic               epDirSel,
  output logic [WORD_W-1:0]  regRdData,
  output logic               irq,
  output logic [CTL_W-1:0]   ctlOut
);
  logic [NUM_EVT-1:0] flagQ;
  logic               shortQ;
  logic [MASK_W-1:0]  maskQ;
  logic [CTL_W-1:0]   ctlQ;
  logic [NUM_EVT-1:0] keepBits;
  logic [WORD_W-1:0]  statusWord;
  logic [WORD_W-1:0]  ctrlWord;
  logic [MASK_W-1:0]  pendVec;

  assign keepBits = strobe.wrStatus ? strobe.data[EVT_LO +: NUM_EVT] : '1;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= evtIn | (flagQ & keepBits);
  end

  generate
    if (HAS_SHORT) begin : g_short
      always_ff @(posedge clk) begin
        if (!rstN) shortQ <= 1'b0;
        else shortQ <= shortPktEvt |
                       (shortQ & (!strobe.wrStatus || strobe.data[SHORT_BIT]));
      end
    end else begin : g_noShort
      assign shortQ = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      ctlQ  <= CTL_RESET;
    end else if (strobe.wrCtrl) begin
      maskQ <= {strobe.data[XFER_BIT:SHORT_BIT+1],
                strobe.data[SHORT_BIT] & HAS_SHORT};
      ctlQ  <= strobe.data[CTL_W-1:0];
    end
  end

  always_comb begin
    statusWord                    = '0;
    statusWord[XFER_BIT]          = anyPending;
    statusWord[EVT_LO +: NUM_EVT] = flagQ;
    statusWord[SHORT_BIT]         = shortQ;
    statusWord[DIR_BIT]           = epDirSel;
    statusWord[EP_ID_W-1:0]       = epIdSel;
    ctrlWord                      = '0;
    ctrlWord[XFER_BIT:SHORT_BIT]  = maskQ;
    ctrlWord[CTL_W-1:0]           = ctlQ;
  end

  assign pendVec   = {anyPending, flagQ, shortQ};
  assign irq       = |(pendVec & maskQ);
  assign regRdData = regAddr ? ctrlWord : statusWord;
  assign ctlOut    = ctlQ;

  // R2: a flag only rises when its event pulsed in the previous cycle
  p_set_by_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ & ~$past(flagQ) & ~$past(evtIn)) == '0);

  // R4: an event always leaves its flag set, whatever was written
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(evtIn) & ~flagQ) == '0);

  // R3: a flag only falls after a status write
  p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flagQ) & ~flagQ)) |-> $past(strobe.wrStatus));

  // R7 / R10: the control word holds when it is not written
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrCtrl) |-> ($stable(ctlQ) && $stable(maskQ)));

  // R9: with every enable off the interrupt line stays low
  p_mask_gates_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);
endmodule

// File: rtl/usbEvtRegs.sv
module usbEvtRegs
  import usbEvtPkg::*;
#(
  parameter int unsigned NUM_EP    = 16,
  parameter bit          HAS_SHORT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  input  logic [6:0]         evtIn,
  input  logic               shortPktEvt,
  input  logic [NUM_EP-1:0]  epDone,
  input  logic [NUM_EP-1:0]  epDir,
  output logic               irq,
  output logic               resumeReq,
  output logic               forceSuspend,
  output logic               lowPower,
  output logic               powerDown,
  output logic               forceReset
);
  regStrobe_t         strobe;
  logic               anyPending;
  logic [EP_ID_W-1:0] epIdSel;
  logic               epDirSel;
  logic [CTL_W-1:0]   ctlOut;

  usbEvtCtrl uCtrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  usbEpSelect #(.NUM_EP(NUM_EP)) uSel (
    .clk        (clk),
    .rstN       (rstN),
    .epDone     (epDone),
    .epDir      (epDir),
    .anyPending (anyPending),
    .epIdSel    (epIdSel),
    .epDirSel   (epDirSel)
  );

  usbEvtDatapath #(.HAS_SHORT(HAS_SHORT)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regAddr     (regAddr),
    .evtIn       (evtIn),
    .shortPktEvt (shortPktEvt),
    .anyPending  (anyPending),
    .epIdSel     (epIdSel),
    .epDirSel    (epDirSel),
    .regRdData   (regRdData),
    .irq         (irq),
    .ctlOut      (ctlOut)
  );

  assign resumeReq    = ctlOut[4];
  assign forceSuspend = ctlOut[3];
  assign lowPower     = ctlOut[2];
  assign powerDown    = ctlOut[1];
  assign forceReset   = ctlOut[0];
endmodule

// File: tb/tb_usbEvtRegs.sv
`timescale 1ns/1ps
module tb_usbEvtRegs;
  localparam int NUM_EP = 16;
  localparam int K_STATUS = 0;
  localparam int K_CTRL = 1;
  localparam int K_OUTS = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regAddr = 1'b0;
  logic [15:0]       regWrData = '0;
  logic [15:0]       regRdData;
  logic [6:0]        evtIn = '0;
  logic              shortPktEvt = 1'b0;
  logic [NUM_EP-1:0] epDone = '0;
  logic [NUM_EP-1:0] epDir = '0;
  logic irq, resumeReq, forceSuspend, lowPower, powerDown, forceReset;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } checkItem_t;

  checkItem_t expQ[$];
  event sampleEv;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usbEvtRegs #(.NUM_EP(NUM_EP), .HAS_SHORT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .shortPktEvt(shortPktEvt), .epDone(epDone), .epDir(epDir), .irq(irq),
    .resumeReq(resumeReq), .forceSuspend(forceSuspend), .lowPower(lowPower),
    .powerDown(powerDown), .forceReset(forceReset)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        checkItem_t it;
        logic [15:0] act;
        it = expQ.pop_front();
        if (it.kind == K_OUTS)
          act = {10'b0, irq, resumeReq, forceSuspend, lowPower, powerDown, forceReset};
        else
          act = regRdData;
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h",
                   it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input logic [15:0] exp, input string tag);
    checkItem_t it;
    @(negedge clk);
    regAddr = (kind == K_CTRL);
    #0.5;
    it.kind = kind; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
    #0.5;
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] data,
                           input logic [6:0] evt, input logic sp);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = sel; regWrData = data;
    evtIn = evt; shortPktEvt = sp;
    @(negedge clk);
    regWrEn = 1'b0; evtIn = '0; shortPktEvt = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] evt, input logic sp);
    @(negedge clk);
    evtIn = evt; shortPktEvt = sp;
    @(negedge clk);
    evtIn = '0; shortPktEvt = 1'b0;
  endtask

  task automatic set_ep(input logic [NUM_EP-1:0] done, input logic [NUM_EP-1:0] dir);
    @(negedge clk);
    epDone = done; epDir = dir;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expect_val(K_STATUS, 16'h0000, "R1 status");
    expect_val(K_CTRL,   16'h0003, "R1 control");
    expect_val(K_OUTS,   16'h0003, "R1 outputs");

    // R2 single event, R9 irq low with mask off
    pulse(7'b0000010, 1'b0);
    expect_val(K_STATUS, 16'h0200, "R2 frame-start flag");
    expect_val(K_OUTS,   16'h0003, "R9 masked irq");

    // R3 write ones keeps, write zero clears
    write_reg(1'b0, 16'hFFFF, '0, 1'b0);
    expect_val(K_STATUS, 16'h0200, "R3 write one keeps");
    write_reg(1'b0, 16'hFDFF, '0, 1'b0);
    expect_val(K_STATUS, 16'h0000, "R3 write zero clears");

    // R2 all events together
    pulse(7'h7F, 1'b1);
    expect_val(K_STATUS, 16'h7F80, "R2 all flags");

    // R4 event collides with a clear
    write_reg(1'b0, 16'h0000, 7'b0100000, 1'b0);
    expect_val(K_STATUS, 16'h2000, "R4 event wins");

    // R7 control read-back, R8 outputs, R9 irq
    write_reg(1'b1, 16'hFFFF, '0, 1'b0);
    expect_val(K_CTRL,   16'hFF9F, "R7 control readback");
    expect_val(K_OUTS,   16'h003F, "R8 R9 outputs all on");
    write_reg(1'b1, 16'h0015, '0, 1'b0);
    expect_val(K_CTRL,   16'h0015, "R7 control readback 2");
    expect_val(K_OUTS,   16'h0015, "R8 control bit order");

    // R10 separation, R9 enable per bit
    write_reg(1'b1, 16'h2000, '0, 1'b0);
    expect_val(K_STATUS, 16'h2000, "R10 status unchanged by control write");
    expect_val(K_OUTS,   16'h0020, "R9 error flag enabled");
    write_reg(1'b0, 16'hDFFF, '0, 1'b0);
    expect_val(K_STATUS, 16'h0000, "R3 targeted clear");
    expect_val(K_CTRL,   16'h2000, "R10 control unchanged by status write");
    expect_val(K_OUTS,   16'h0000, "R9 irq drops after clear");

    // R5 R6 endpoints
    set_ep(16'h0220, 16'h0020);
    expect_val(K_STATUS, 16'h8015, "R5 R6 lowest endpoint 5");
    expect_val(K_OUTS,   16'h0000, "R9 transfer flag not enabled");
    write_reg(1'b1, 16'h8000, '0, 1'b0);
    expect_val(K_OUTS,   16'h0020, "R9 transfer flag enabled");
    write_reg(1'b0, 16'h0000, '0, 1'b0);
    expect_val(K_STATUS, 16'h8015, "R5 R6 not writable");
    set_ep(16'h0200, 16'h0020);
    expect_val(K_STATUS, 16'h8009, "R6 endpoint 9 direction 0");
    set_ep(16'h0001, 16'h0001);
    expect_val(K_STATUS, 16'h8010, "R6 endpoint 0 direction 1");
    set_ep(16'h8000, 16'h0000);
    expect_val(K_STATUS, 16'h800F, "R6 top endpoint");
    set_ep(16'h0000, 16'h0000);
    expect_val(K_STATUS, 16'h0000, "R5 R6 none pending");
    expect_val(K_OUTS,   16'h0000, "R9 irq low when none pending");

    // R2 short packet flag with its enable
    write_reg(1'b1, 16'h0080, '0, 1'b0);
    pulse(7'b0, 1'b1);
    expect_val(K_STATUS, 16'h0080, "R2 short packet flag");
    expect_val(K_OUTS,   16'h0020, "R9 short packet irq");
    write_reg(1'b0, 16'hFF7F, '0, 1'b0);
    expect_val(K_STATUS, 16'h0000, "R3 short packet clear");

    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule